// File: doc/BRIEF.md
# DMA channel register and interrupt block

This block is the register front end of a sixteen-channel two-dimensional DMA controller. Each channel serves one fixed peripheral. Software programs a channel over a simple register bus in a set order. It writes the control word first, then the row length, the row count and the line pitch. The buffer address goes last. Writing the address is the start command. The block then sends a one-cycle launch pulse, along with the stored parameters, to that channel's transfer engine.

A transfer is stopped by writing ones to a shared stop register. Each one bit sends a one-cycle abort pulse to the matching channel. When an engine finishes, it returns a completion pulse. That pulse sets the channel's status bit, and the status bit stays set until software clears it by writing a one to it. A single interrupt line is raised while any channel has both its status bit and its enable bit set. Reading the stop register returns the busy flag of each channel.

Top module: `dmac_csr_unit`

## Requirements
- R1: After reset, every register reads 0, irq_o is low, and launch_o and abort_o are all zero.
- R2: Channel c has four registers at byte offset c*0x10. The control word is at +0x0, the row length at +0x4, the row count at +0x8 and the address at +0xC. Each one reads back the value written and drives the matching per-channel output slice.
- R3: The line pitch of channel c is at 0x100 + c*4. It reads back the value written and drives width_o.
- R4: In the control word, bits [3:0] hold the channel number and are stored as written. Bit 4 drives mode_o[c] and bit 5 drives dir_o[c].
- R5: A write to the address register of channel c raises launch_o[c] for exactly the one cycle after the write. It also sets busy bit c, which reads back at 0x148.
- R6: A write to 0x148 raises abort_o for one cycle on every bit written as 1, and clears those busy bits. Bits written as 0 have no effect.
- R7: done_i[c] sets status bit c (register 0x144) whatever the enable bit holds, and it clears busy bit c.
- R8: Writing 1 to a bit of 0x144 clears that status bit. Writing 0 leaves it unchanged.
- R9: When a completion pulse and a clear write hit the same status bit in the same cycle, the bit stays set.
- R10: irq_o is the OR over channels of (status AND enable). The enable register is at 0x140, one bit per channel at bit c. irq_o reflects a change from the cycle after the causing edge.
- R11: Read data appears on rdata_o in the cycle after rd_i and is 0 in every other cycle. Unmapped or misaligned addresses read 0 and ignore writes.
- R12: If a launch and a completion pulse hit the same channel in the same cycle, the busy bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | DW | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | DW | Read data, one cycle after rd_i |
| launch_o | output | NUM_CH | Per-channel start pulse |
| abort_o | output | NUM_CH | Per-channel stop pulse |
| done_i | input | NUM_CH | Per-channel completion pulse |
| mode_o | output | NUM_CH | Per-channel burst mode |
| dir_o | output | NUM_CH | Per-channel direction |
| xlen_o | output | NUM_CH*DW | Row length, one slice per channel |
| ylen_o | output | NUM_CH*DW | Row count, one slice per channel |
| addr_o | output | NUM_CH*DW | Buffer address, one slice per channel |
| width_o | output | NUM_CH*DW | Line pitch, one slice per channel |
| irq_o | output | 1 | Combined interrupt |

## Verification
Every result of this block is due one cycle after the clock edge that samples its cause. This holds for read data, for the launch and abort pulses, and for status and irq_o after a completion pulse or a clear. The bench drives all stimulus on the falling edge. It checks pulses and irq_o on the next falling edge, and it checks a pulse again one cycle later to confirm it has dropped. Reads go through a scoreboard: the driver queues the expected word, and a monitor pops and compares it on the falling edge that follows the capturing rising edge.

// File: rtl/dmac_csr_pkg.sv
package dmac_csr_pkg;
  localparam int unsigned DW        = 32;
  localparam int unsigned OFF_WIDTH = 'h100;
  localparam int unsigned OFF_IEN   = 'h140;
  localparam int unsigned OFF_IST   = 'h144;
  localparam int unsigned OFF_VALID = 'h148;
  localparam int unsigned MODE_BIT  = 4;
  localparam int unsigned DIR_BIT   = 5;

  typedef enum logic [1:0] {
    SLOT_CTRL = 2'd0,
    SLOT_XLEN = 2'd1,
    SLOT_YLEN = 2'd2,
    SLOT_ADDR = 2'd3
  } slot_e;

  typedef struct packed {
    logic  chan_hit;
    logic  width_hit;
    logic  ien_hit;
    logic  ist_hit;
    logic  vld_hit;
    slot_e slot;
  } dec_t;
endpackage

// File: rtl/dmac_addr_dec.sv
module dmac_addr_dec
  import dmac_csr_pkg::*;
#(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned ADDR_W = 12,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output dec_t              dec_o,
  output logic [CH_W-1:0]   idx_o
);
  localparam int unsigned CHAN_END  = NUM_CH * 16;
  localparam int unsigned WIDTH_END = OFF_WIDTH + NUM_CH * 4;

  int unsigned a;
  logic aligned;

  always_comb begin
    a       = 32'(addr_i);
    aligned = (addr_i[1:0] == 2'b00);
    dec_o.chan_hit  = aligned && (a < CHAN_END);
    dec_o.width_hit = aligned && (a >= OFF_WIDTH) && (a < WIDTH_END);
    dec_o.ien_hit   = (a == OFF_IEN);
    dec_o.ist_hit   = (a == OFF_IST);
    dec_o.vld_hit   = (a == OFF_VALID);
    dec_o.slot      = slot_e'(addr_i[3:2]);
    // channel blocks sit on a 16-byte stride, pitch array on a 4-byte stride
    if (dec_o.width_hit) idx_o = addr_i[2 +: CH_W];
    else                 idx_o = addr_i[4 +: CH_W];
  end
endmodule

// File: rtl/dmac_chan_regs.sv
module dmac_chan_regs
  import dmac_csr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          blk_we_i,
  input  slot_e         slot_i,
  input  logic          width_we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          stop_i,
  input  logic          done_i,
  output logic [DW-1:0] ctrl_o,
  output logic [DW-1:0] xlen_o,
  output logic [DW-1:0] ylen_o,
  output logic [DW-1:0] addr_o,
  output logic [DW-1:0] width_o,
  output logic          launch_o,
  output logic          abort_o,
  output logic          busy_o
);
  logic go;
  assign go = blk_we_i && (slot_i == SLOT_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o   <= '0;
      xlen_o   <= '0;
      ylen_o   <= '0;
      addr_o   <= '0;
      width_o  <= '0;
      launch_o <= 1'b0;
      abort_o  <= 1'b0;
      busy_o   <= 1'b0;
    end else begin
      if (blk_we_i) begin
        unique case (slot_i)
          SLOT_CTRL: ctrl_o <= wdata_i;
          SLOT_XLEN: xlen_o <= wdata_i;
          SLOT_YLEN: ylen_o <= wdata_i;
          SLOT_ADDR: addr_o <= wdata_i;
        endcase
      end
      if (width_we_i) width_o <= wdata_i;
      launch_o <= go;
      abort_o  <= stop_i;
      // launch wins over a same-cycle completion
      if (go)                  busy_o <= 1'b1;
      else if (stop_i || done_i) busy_o <= 1'b0;
    end
  end
endmodule

// File: rtl/dmac_irq_ctrl.sv
module dmac_irq_ctrl #(
  parameter int unsigned NUM_CH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ien_we_i,
  input  logic              ist_we_i,
  input  logic [NUM_CH-1:0] wbits_i,
  input  logic [NUM_CH-1:0] done_i,
  output logic [NUM_CH-1:0] ien_o,
  output logic [NUM_CH-1:0] ist_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0] clr;
  assign clr = ist_we_i ? wbits_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_o <= '0;
      ist_o <= '0;
    end else begin
      if (ien_we_i) ien_o <= wbits_i;
      ist_o <= (ist_o & ~clr) | done_i;  // set dominates clear
    end
  end

  assign irq_o = |(ist_o & ien_o);
endmodule

// File: rtl/dmac_csr_unit.sv
module dmac_csr_unit
  import dmac_csr_pkg::*;
#(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned ADDR_W = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DW-1:0]        wdata_i,
  input  logic                 wr_i,
  input  logic                 rd_i,
  output logic [DW-1:0]        rdata_o,
  output logic [NUM_CH-1:0]    launch_o,
  output logic [NUM_CH-1:0]    abort_o,
  input  logic [NUM_CH-1:0]    done_i,
  output logic [NUM_CH-1:0]    mode_o,
  output logic [NUM_CH-1:0]    dir_o,
  output logic [NUM_CH*DW-1:0] xlen_o,
  output logic [NUM_CH*DW-1:0] ylen_o,
  output logic [NUM_CH*DW-1:0] addr_o,
  output logic [NUM_CH*DW-1:0] width_o,
  output logic                 irq_o
);
  localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  dec_t            dec;
  logic [CH_W-1:0] idx;

  logic [DW-1:0]     ctrl_a  [NUM_CH];
  logic [DW-1:0]     xlen_a  [NUM_CH];
  logic [DW-1:0]     ylen_a  [NUM_CH];
  logic [DW-1:0]     addr_a  [NUM_CH];
  logic [DW-1:0]     width_a [NUM_CH];
  logic [NUM_CH-1:0] busy_q;
  logic [NUM_CH-1:0] ien_q;
  logic [NUM_CH-1:0] ist_q;
  logic [NUM_CH-1:0] stop;

  dmac_addr_dec #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .dec_o  (dec),
    .idx_o  (idx)
  );

  assign stop = (wr_i && dec.vld_hit) ? wdata_i[NUM_CH-1:0] : '0;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic sel;
    assign sel = (32'(idx) == c);

    dmac_chan_regs u_regs (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .blk_we_i   (wr_i && dec.chan_hit && sel),
      .slot_i     (dec.slot),
      .width_we_i (wr_i && dec.width_hit && sel),
      .wdata_i    (wdata_i),
      .stop_i     (stop[c]),
      .done_i     (done_i[c]),
      .ctrl_o     (ctrl_a[c]),
      .xlen_o     (xlen_a[c]),
      .ylen_o     (ylen_a[c]),
      .addr_o     (addr_a[c]),
      .width_o    (width_a[c]),
      .launch_o   (launch_o[c]),
      .abort_o    (abort_o[c]),
      .busy_o     (busy_q[c])
    );

    assign mode_o[c]            = ctrl_a[c][MODE_BIT];
    assign dir_o[c]             = ctrl_a[c][DIR_BIT];
    assign xlen_o[c*DW +: DW]   = xlen_a[c];
    assign ylen_o[c*DW +: DW]   = ylen_a[c];
    assign addr_o[c*DW +: DW]   = addr_a[c];
    assign width_o[c*DW +: DW]  = width_a[c];
  end

  dmac_irq_ctrl #(.NUM_CH(NUM_CH)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ien_we_i (wr_i && dec.ien_hit),
    .ist_we_i (wr_i && dec.ist_hit),
    .wbits_i  (wdata_i[NUM_CH-1:0]),
    .done_i   (done_i),
    .ien_o    (ien_q),
    .ist_o    (ist_q),
    .irq_o    (irq_o)
  );

  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (dec.chan_hit) begin
      unique case (dec.slot)
        SLOT_CTRL: rd_mux = ctrl_a[idx];
        SLOT_XLEN: rd_mux = xlen_a[idx];
        SLOT_YLEN: rd_mux = ylen_a[idx];
        SLOT_ADDR: rd_mux = addr_a[idx];
      endcase
    end else if (dec.width_hit) rd_mux = width_a[idx];
    else if (dec.ien_hit)       rd_mux[NUM_CH-1:0] = ien_q;
    else if (dec.ist_hit)       rd_mux[NUM_CH-1:0] = ist_q;
    else if (dec.vld_hit)       rd_mux[NUM_CH-1:0] = busy_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= rd_i ? rd_mux : '0;
  end
endmodule

// File: rtl/dmac_csr_chk.sv
module dmac_csr_chk
  import dmac_csr_pkg::*;
#(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [DW-1:0]     rdata_o,
  input logic [NUM_CH-1:0] launch_o,
  input logic [NUM_CH-1:0] abort_o,
  input logic [NUM_CH-1:0] done_i,
  input logic              irq_o,
  input logic [NUM_CH-1:0] busy_q,
  input logic [NUM_CH-1:0] ien_q,
  input logic [NUM_CH-1:0] ist_q
);
  p_launch_from_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|launch_o) |-> $past(wr_i));

  p_launch_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|launch_o) |-> ((busy_q & launch_o) == launch_o));

  p_abort_from_stop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|abort_o) |-> $past(wr_i && (32'(addr_i) == OFF_VALID)));

  p_abort_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|abort_o) |-> ((busy_q & abort_o) == '0));

  p_done_sticks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|done_i) |=> ((ist_q & $past(done_i)) == $past(done_i)));

  p_irq_on_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|(done_i & ien_q)) && !(wr_i && (32'(addr_i) == OFF_IEN))) |=> irq_o);

  p_irq_cause_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(|done_i) || $past(wr_i)));

  p_rdata_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rd_i) |-> (rdata_o == '0));
endmodule

bind dmac_csr_unit dmac_csr_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .wr_i     (wr_i),
  .rd_i     (rd_i),
  .rdata_o  (rdata_o),
  .launch_o (launch_o),
  .abort_o  (abort_o),
  .done_i   (done_i),
  .irq_o    (irq_o),
  .busy_q   (busy_q),
  .ien_q    (ien_q),
  .ist_q    (ist_q)
);

// File: tb/dmac_csr_unit_tb.sv
module dmac_csr_unit_tb;
  localparam int NCH = 16;
  localparam int AW  = 12;
  localparam int W   = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [W-1:0]  wdata = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [W-1:0] rdata;
  logic [NCH-1:0] launch, abort_p, done = '0, mode, dir;
  logic [NCH*W-1:0] xlen, ylen, addro, width;
  logic irq;

  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dmac_csr_unit #(.NUM_CH(NCH), .ADDR_W(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .wr_i(wr), .rd_i(rd), .rdata_o(rdata), .launch_o(launch),
    .abort_o(abort_p), .done_i(done), .mode_o(mode), .dir_o(dir),
    .xlen_o(xlen), .ylen_o(ylen), .addr_o(addro), .width_o(width),
    .irq_o(irq)
  );

  logic [W-1:0] exp_q[$];
  string        tag_q[$];
  logic rd_d = 1'b0;

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_d <= rd;

  // monitor: compare read data against the scoreboard
  always @(negedge clk) begin
    if (rd_d) begin
      if (exp_q.size() == 0) chk("R11 unexpected read", rdata, '1);
      else chk(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic wr_reg(int a, logic [W-1:0] d, logic [NCH-1:0] dn = '0);
    @(negedge clk);
    addr = AW'(a); wdata = d; wr = 1'b1; done = dn;
    @(negedge clk);
    wr = 1'b0; done = '0;
  endtask

  task automatic rd_reg(int a, logic [W-1:0] exp, string tag);
    @(negedge clk);
    exp_q.push_back(exp); tag_q.push_back(tag);
    addr = AW'(a); rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_done(logic [NCH-1:0] dn);
    @(negedge clk);
    done = dn;
    @(negedge clk);
    done = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", W'(irq), 0);
    chk("R1 launch", W'(launch), 0);
    chk("R1 abort", W'(abort_p), 0);
    rd_reg('h50, 0, "R1 ctrl5");
    rd_reg('h144, 0, "R1 status");
    rd_reg('h148, 0, "R1 busy");

    // R2 / R4 channel block
    wr_reg('h54, 32'h0000_0123);
    wr_reg('h58, 32'h0000_0040);
    wr_reg('h50, 32'h0000_0035);
    wr_reg('hF0, 32'h0000_001F);
    rd_reg('h54, 32'h123, "R2 xlen5");
    rd_reg('h58, 32'h40, "R2 ylen5");
    rd_reg('h50, 32'h35, "R4 ctrl5");
    rd_reg('hF0, 32'h1F, "R4 ctrl15");
    chk("R2 xlen_o", xlen[5*W +: W], 32'h123);
    chk("R2 ylen_o", ylen[5*W +: W], 32'h40);
    chk("R4 mode_o", W'(mode), 32'h8020);
    chk("R4 dir_o", W'(dir), 32'h0020);

    // R3 pitch array
    wr_reg('h114, 32'h200);
    wr_reg('h13C, 32'h77);
    rd_reg('h114, 32'h200, "R3 width5");
    rd_reg('h13C, 32'h77, "R3 width15");
    chk("R3 width_o", width[15*W +: W], 32'h77);

    // R5 launch on address write
    wr_reg('h5C, 32'h1000_0000);
    chk("R5 launch pulse", W'(launch), 32'h20);
    @(negedge clk);
    chk("R5 launch drop", W'(launch), 0);
    chk("R2 addr_o", addro[5*W +: W], 32'h1000_0000);
    rd_reg('h5C, 32'h1000_0000, "R2 addr5");
    rd_reg('h148, 32'h20, "R5 busy");

    // R7 completion with enable off
    pulse_done(16'h0020);
    chk("R7 irq masked", W'(irq), 0);
    rd_reg('h144, 32'h20, "R7 status");
    rd_reg('h148, 0, "R7 busy cleared");

    // R10 enable raises irq
    wr_reg('h140, 32'h20);
    chk("R10 irq", W'(irq), 1);
    rd_reg('h140, 32'h20, "R10 enable");

    // R8 write-one-to-clear
    wr_reg('h144, 32'h0);
    rd_reg('h144, 32'h20, "R8 zero keeps");
    chk("R8 irq kept", W'(irq), 1);
    wr_reg('h144, 32'h20);
    chk("R8 irq cleared", W'(irq), 0);
    rd_reg('h144, 0, "R8 cleared");

    // R6 stop
    wr_reg('hFC, 32'h1);
    wr_reg('h2C, 32'h2);
    rd_reg('h148, 32'h8004, "R6 busy before");
    wr_reg('h148, 32'h8000);
    chk("R6 abort pulse", W'(abort_p), 32'h8000);
    @(negedge clk);
    chk("R6 abort drop", W'(abort_p), 0);
    rd_reg('h148, 32'h0004, "R6 busy after");
    wr_reg('h148, 32'h0);
    chk("R6 zero no abort", W'(abort_p), 0);
    rd_reg('h148, 32'h0004, "R6 zero keeps busy");

    // R9 set beats clear
    wr_reg('h144, 32'h4, 16'h0004);
    rd_reg('h144, 32'h4, "R9 status kept");
    wr_reg('h144, 32'h4);
    rd_reg('h144, 0, "R9 cleared later");

    // R12 launch and done on one channel together
    wr_reg('h2C, 32'h3, 16'h0004);
    chk("R12 launch", W'(launch), 32'h4);
    rd_reg('h148, 32'h4, "R12 busy set");
    rd_reg('h144, 32'h4, "R12 status set");

    // R11 unmapped and misaligned
    rd_reg('h200, 0, "R11 unmapped read");
    wr_reg('h14C, 32'hFFFF);
    rd_reg('h14C, 0, "R11 unmapped write");
    rd_reg('h140, 32'h20, "R11 enable unchanged");
    wr_reg('h51, 32'hAA);
    rd_reg('h50, 32'h35, "R11 misaligned ignored");
    chk("R11 rdata idle", rdata, 0);

    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) chk("R11 pending reads", W'(exp_q.size()), 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule